// File: doc/BRIEF.md
# Connection Memory Clear Sequencer

At power-up a switching connection store holds arbitrary words, so random paths may be live. This block clears that store by hardware instead of software writes. Software programs a small three-register window: a mode byte, an index byte that selects a diagnostic slot, and a data byte. When the mode byte is 0x00 and the index byte is 0x30, writing the code 0x0C to the data byte starts a sweep. The sweep writes one location per clock, in ascending order from 0 to 1023. Each 16-bit word gets its own 10-bit address in bits 9:0 and zero in the six control bits 15:10, which turns off every connection.

Software polls bit 0 of the data byte while the index is 0x30 to see when the sweep is done. It then writes 0x00 to the data byte, with the index still 0x30, to leave diagnostic mode. The block drives a write port into the connection store, which lives outside it. It also exports the completion and diagnostic-mode flags.

Top module: `conn_mem_init`

## Requirements
- R1: After reset, `mem_we`, `sweep_done` and `diag_active` are 0, and reads of all four register selects return 0x00.
- R2: A write to the data select (`reg_sel`=2) with value 0x0C starts a sweep when the mode register is 0x00 and the index register is 0x30. `mem_we` is high with `mem_addr`=0 in the cycle after the write edge.
- R3: During a sweep, one word is written per clock at ascending addresses 0..1023. Each word is `{6'b0, address}`, so after the sweep every word's upper six bits are 0 and its lower ten bits equal its address.
- R4: After the 1024th write, `mem_we` drops and `sweep_done` is set in the same cycle. While the index register is 0x30, a read of the data select returns 0x01. With any other index value, that read returns 0x00.
- R5: A data write does not start a sweep when the mode register is not 0x00, when the index register is not 0x30, or when the value is not 0x0C.
- R6: A start write during a running sweep is ignored, and the address sequence continues without restarting.
- R7: Writing 0x00 to the data select with the index register at 0x30 clears `sweep_done` and `diag_active`. This happens only after completion. The same write during a running sweep, or while idle, has no effect.
- R8: Register selects are encoded as 0 = mode, 1 = index, 2 = data, 3 = unused. The mode and index registers read back their last written value, and select 3 reads 0x00.
- R9: A start write accepted while `sweep_done` is set begins a new sweep from address 0 and clears `sweep_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 mode, 1 index, 2 data, 3 unused) |
| reg_wdata | input | 8 | Register write value |
| reg_rdata | output | 8 | Combinational read value for `reg_sel` |
| mem_we | output | 1 | Connection store write enable |
| mem_addr | output | 10 | Connection store write address |
| mem_wdata | output | 16 | Connection store write word |
| sweep_done | output | 1 | Sweep complete flag |
| diag_active | output | 1 | Diagnostic mode active (sweep running or done) |

## Verification
Some properties are checked on every cycle. A sweep always begins at address 0, and only right after a valid start write. Consecutive write cycles step the address by exactly one, and the control bits of every written word are zero. Completion coincides with the end of the write burst, and diagnostic mode is left only through an exit write.

The bench scenarios cover the rest. They show that the whole store really holds its own addresses afterwards. They show which mode, index and code combinations are rejected, and that start and exit writes are dropped mid-sweep. They also show the read-back values and that a restart from the completed state works.

// File: rtl/cmie_pkg.sv
`timescale 1ns/1ps
package cmie_pkg;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_RUN  = 2'd1,
        SW_DONE = 2'd2
    } sweep_state_e;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_INDEX = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/cmie_regfile.sv
`timescale 1ns/1ps
module cmie_regfile
    import cmie_pkg::*;
#(
    parameter int               REG_W      = 8,
    parameter logic [REG_W-1:0] DIAG_IDX   = 8'h30,
    parameter logic [REG_W-1:0] START_CODE = 8'h0C,
    parameter logic [REG_W-1:0] EXIT_CODE  = 8'h00,
    parameter logic [REG_W-1:0] MODE_SWEEP = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       sel_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             done_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             start_o,
    output logic             exit_o
);

    typedef struct packed {
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] index;
    } regs_t;

    regs_t r_d, r_q;
    logic  idx_hit;

    always_comb begin
        r_d     = r_q;
        start_o = 1'b0;
        exit_o  = 1'b0;
        rdata_o = '0;
        idx_hit = (r_q.index == DIAG_IDX);

        if (wr_i) begin
            case (reg_sel_e'(sel_i))
                SEL_MODE:  r_d.mode  = wdata_i;
                SEL_INDEX: r_d.index = wdata_i;
                SEL_DATA: begin
                    if (idx_hit) begin
                        if (wdata_i == START_CODE && r_q.mode == MODE_SWEEP)
                            start_o = 1'b1;
                        if (wdata_i == EXIT_CODE)
                            exit_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        case (reg_sel_e'(sel_i))
            SEL_MODE:  rdata_o = r_q.mode;
            SEL_INDEX: rdata_o = r_q.index;
            SEL_DATA:  rdata_o = idx_hit ? {{(REG_W-1){1'b0}}, done_i} : '0;
            default:   rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/cmie_sweep.sv
`timescale 1ns/1ps
module cmie_sweep
    import cmie_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              exit_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              done_o,
    output logic              diag_o
);

    localparam int CTRL_W = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    typedef struct packed {
        sweep_state_e      st;
        logic [ADDR_W-1:0] cnt;
    } sweep_t;

    sweep_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SW_IDLE: begin
                if (start_i) begin
                    s_d.st  = SW_RUN;
                    s_d.cnt = '0;
                end
            end
            SW_RUN: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == LAST_ADDR)
                    s_d.st = SW_DONE;
            end
            SW_DONE: begin
                if (start_i) begin
                    s_d.st  = SW_RUN;
                    s_d.cnt = '0;
                end else if (exit_i) begin
                    s_d.st = SW_IDLE;
                end
            end
            default: s_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SW_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign mem_we_o    = (s_q.st == SW_RUN);
    assign mem_addr_o  = s_q.cnt;
    assign mem_wdata_o = {{CTRL_W{1'b0}}, s_q.cnt};
    assign done_o      = (s_q.st == SW_DONE);
    assign diag_o      = (s_q.st != SW_IDLE);

endmodule

// File: rtl/conn_mem_init.sv
`timescale 1ns/1ps
module conn_mem_init #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              sweep_done,
    output logic              diag_active
);

    logic start_req;
    logic exit_req;

    cmie_regfile #(
        .REG_W      (REG_W),
        .DIAG_IDX   (REG_W'(8'h30)),
        .START_CODE (REG_W'(8'h0C)),
        .EXIT_CODE  (REG_W'(8'h00)),
        .MODE_SWEEP (REG_W'(8'h00))
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .sel_i   (reg_sel),
        .wdata_i (reg_wdata),
        .done_i  (sweep_done),
        .rdata_o (reg_rdata),
        .start_o (start_req),
        .exit_o  (exit_req)
    );

    cmie_sweep #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_req),
        .exit_i      (exit_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .done_o      (sweep_done),
        .diag_o      (diag_active)
    );

endmodule

// File: rtl/conn_mem_init_chk.sv
`timescale 1ns/1ps
module conn_mem_init_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              sweep_done,
    input logic              diag_active
);

    // R2: a burst always opens at address 0
    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> mem_addr == '0);

    // R5: a burst only follows a write of the start code to the data select
    a_r5_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(reg_wr && reg_sel == 2'd2 && reg_wdata == REG_W'(8'h0C)));

    // R6: back-to-back writes step by one, no restart mid-sweep
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    // R3: control bits of every written word are zero
    a_r3_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[DATA_W-1:ADDR_W] == '0);

    // R4: burst end coincides with completion
    a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> sweep_done);

    // R4: no writes while complete, and completion implies diagnostic mode
    a_r4_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (!mem_we && diag_active));

    // R7: diagnostic mode is left only through an exit write
    a_r7_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(diag_active) |-> $past(reg_wr && reg_sel == 2'd2 && reg_wdata == REG_W'(8'h00)));

endmodule

bind conn_mem_init conn_mem_init_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .sweep_done  (sweep_done),
    .diag_active (diag_active)
);

// File: tb/sim_conn_mem_init.sv
`timescale 1ns/1ps
module sim_conn_mem_init;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        mem_we;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        sweep_done;
    logic        diag_active;

    int checks = 0;
    int failures = 0;

    logic [15:0] store [0:1023];

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    conn_mem_init u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sweep_done(sweep_done),
        .diag_active(diag_active)
    );

    always @(posedge clk) if (mem_we) store[mem_addr] <= mem_wdata;

    // {mode, index, code, expect_start}
    localparam logic [24:0] VEC [7] = '{
        {8'h00, 8'h30, 8'h0C, 1'b1},
        {8'h01, 8'h30, 8'h0C, 1'b0},
        {8'h00, 8'h31, 8'h0C, 1'b0},
        {8'h00, 8'h30, 8'h0D, 1'b0},
        {8'h80, 8'h30, 8'h0C, 1'b0},
        {8'h00, 8'h00, 8'h0C, 1'b0},
        {8'h00, 8'h30, 8'h0C, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
        reg_sel = 2'd3;
    endtask

    task automatic leave_diag();
        wr(2'd1, 8'h30);
        wr(2'd2, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int bad;
        for (int i = 0; i < 1024; i++)
            store[i] = 16'(i * 40503 + 16'hBEEF) | 16'hFC00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!mem_we && !sweep_done && !diag_active, "R1 flags", {mem_we, sweep_done, diag_active}, 0);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk(v == 8'h00, "R1 read", v, 0);
        end

        // R8 read-back
        wr(2'd0, 8'h5A); rd(2'd0, v); chk(v == 8'h5A, "R8 mode", v, 8'h5A);
        wr(2'd1, 8'hC3); rd(2'd1, v); chk(v == 8'hC3, "R8 index", v, 8'hC3);
        rd(2'd3, v); chk(v == 8'h00, "R8 unused", v, 0);

        // R7 exit while idle has no effect
        leave_diag();
        chk(!diag_active && !sweep_done && !mem_we, "R7 idle exit", diag_active, 0);

        // main sweep with mid-run start (R6) and exit (R7) injected
        wr(2'd0, 8'h00); wr(2'd1, 8'h30); wr(2'd2, 8'h0C);
        chk(mem_we && mem_addr == 0, "R2 start", mem_addr, 0);
        bad = 0;
        for (int i = 0; i < 1024; i++) begin
            if (!(mem_we && mem_addr == 10'(i) && mem_wdata == 16'(i))) bad++;
            if (i == 100) begin
                reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h0C;
            end else if (i == 200) begin
                reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h00;
            end else begin
                reg_wr = 1'b0; reg_sel = 2'd3;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0; reg_sel = 2'd3;
        chk(bad == 0, "R6 sequence", bad, 0);
        chk(!mem_we && sweep_done && diag_active, "R4 done", {mem_we, sweep_done, diag_active}, 3'b011);
        rd(2'd2, v); chk(v == 8'h01, "R4 status", v, 8'h01);
        wr(2'd1, 8'h31);
        rd(2'd2, v); chk(v == 8'h00, "R4 other index", v, 0);

        bad = 0;
        for (int i = 0; i < 1024; i++)
            if (store[i] !== 16'(i)) bad++;
        chk(bad == 0, "R3 contents", bad, 0);

        leave_diag();
        chk(!sweep_done && !diag_active, "R7 exit", {sweep_done, diag_active}, 0);
        rd(2'd2, v); chk(v == 8'h00, "R7 status cleared", v, 0);

        // R5 / R2 table
        for (int k = 0; k < 7; k++) begin
            wr(2'd0, VEC[k][24:17]);
            wr(2'd1, VEC[k][16:9]);
            wr(2'd2, VEC[k][8:1]);
            if (VEC[k][0]) begin
                chk(mem_we && mem_addr == 0, "R2 table start", mem_we, 1);
                repeat (1024) @(negedge clk);
                chk(sweep_done && !mem_we, "R4 table done", sweep_done, 1);
                leave_diag();
                chk(!diag_active, "R7 table exit", diag_active, 0);
            end else begin
                chk(!mem_we, "R5 rejected", mem_we, 0);
                @(negedge clk);
                chk(!mem_we && !diag_active, "R5 stays idle", {mem_we, diag_active}, 0);
            end
        end

        // R9 restart from completed state
        wr(2'd0, 8'h00); wr(2'd1, 8'h30); wr(2'd2, 8'h0C);
        repeat (1024) @(negedge clk);
        chk(sweep_done, "R9 first done", sweep_done, 1);
        wr(2'd2, 8'h0C);
        chk(mem_we && mem_addr == 0 && !sweep_done, "R9 restart", mem_addr, 0);
        repeat (1024) @(negedge clk);
        chk(sweep_done && !mem_we, "R9 second done", sweep_done, 1);
        leave_diag();
        chk(!diag_active && !sweep_done, "R7 final exit", diag_active, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule